// File: doc/BRIEF.md
# Address Generation and Branch Unit

This block forms every memory address and every program-counter update for a 16-bit word-addressed machine. On each cycle it takes the operand bits of the current instruction, the program counter after the fetch increment, a base register, a jump register, a bus word and the three result flags (negative, zero, positive). From these it produces the address for the memory address register, the next program counter, a branch-taken indication and the computed address used by the load-effective-address operation. The control sequencer picks the addressing form and the sources with a few select inputs.

A single adder serves every address form. Its base is the incremented PC, a base register, a jump register or zero. Its offset is a sign-extended 9-bit field, a sign-extended 6-bit field or zero. The sum goes to the memory address selector, which also accepts a zero-extended 8-bit service-routine vector. It also goes to the PC selector, which also accepts the sequential PC and the bus. A conditional branch uses the adder result only when the condition mask in the instruction finds a matching flag. All outputs are registered and appear on the clock edge after the inputs are presented.

Top module: `addr_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four outputs become zero. Otherwise each output takes the value computed from the inputs sampled at that edge.
- R2: With `addr_mode` = 0 (PC-relative), the adder result is `pc_inc` plus `instr_fld[8:0]` sign-extended to 16 bits. Field 0x0FF adds +255 and field 0x100 adds -256.
- R3: With `addr_mode` = 1 (base plus offset), the adder result is `base_val` plus `instr_fld[5:0]` sign-extended. Field 0x1F adds +31 and field 0x20 adds -32.
- R4: With `addr_mode` = 2 (register jump), the adder result is exactly `jump_val`.
- R5: With `addr_mode` = 3 (zero-based), the adder result is `instr_fld[8:0]` sign-extended.
- R6: `lea_val` always carries the adder result, whatever the values of `mar_sel`, `pc_sel` and `cond_br`.
- R7: `mar_sel` = 0 routes the adder result to `mar_addr`. `mar_sel` = 1 routes `instr_fld[7:0]` zero-extended, and `instr_fld[11:8]` have no effect on that value.
- R8: `pc_sel` = 0 or 3 gives `next_pc` = `pc_inc`. `pc_sel` = 2 gives `bus_val`. `pc_sel` = 1 gives the adder result, subject to R9.
- R9: With `pc_sel` = 1 and `cond_br` = 1, the redirect happens only if `instr_fld[11:9]` ANDed with {N,Z,P} is nonzero (bit 11 pairs with N, bit 10 with Z, bit 9 with P). Otherwise `next_pc` = `pc_inc`. `cond_br` has no effect for any other `pc_sel` value.
- R10: A conditional branch with mask 000 is never taken, even with all flags set. A mask of 111 is taken whenever any flag is set.
- R11: `br_taken` is 1 exactly when `next_pc` was taken from the adder.
- R12: The adder wraps modulo 2^16: 0xFFFF + 1 gives 0x0000, and 0x0000 - 1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_fld | input | 12 | Instruction bits 11..0: condition mask in 11..9, offsets in the low bits |
| pc_inc | input | 16 | Program counter after the fetch increment |
| base_val | input | 16 | Base register value for base-plus-offset addressing |
| jump_val | input | 16 | Register value used as a jump target |
| bus_val | input | 16 | Bus word, used as a PC source for service calls |
| flag_n | input | 1 | Negative result flag |
| flag_z | input | 1 | Zero result flag |
| flag_p | input | 1 | Positive result flag |
| addr_mode | input | 2 | Adder form: 0 PC-relative, 1 base+offset, 2 register jump, 3 zero-based |
| pc_sel | input | 2 | PC source: 0/3 sequential, 1 adder, 2 bus |
| mar_sel | input | 1 | Memory address source: 0 adder, 1 zero-extended vector |
| cond_br | input | 1 | Makes an adder redirect conditional on the mask |
| mar_addr | output | 16 | Registered memory address |
| next_pc | output | 16 | Registered next program counter |
| br_taken | output | 1 | Registered: next PC came from the adder |
| lea_val | output | 16 | Registered adder result |

## Verification
The hardest cases to reach are the sign-extension boundaries and the wrap of the adder. Uniform random 12-bit fields seldom land exactly on 0x0FF/0x100 or 0x1F/0x20, and random PC values almost never sit at 0xFFFF. Directed vectors place those fields and operands exactly. Random vectors draw the mask and flags separately, so every mask meets flag patterns that match it and patterns that do not, including all-clear and all-set flags.

// File: rtl/abu_pkg.sv
// Package abu_pkg: select encodings shared by the address/branch unit.
// Assumes the control sequencer drives these codes on plain 2-bit and
// 1-bit wires; the top module casts them into these types.
package abu_pkg;

    typedef enum logic [1:0] {
        AM_PCREL   = 2'd0,
        AM_BASEOFF = 2'd1,
        AM_REGJMP  = 2'd2,
        AM_ZERO    = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        PS_SEQ     = 2'd0,
        PS_ADDER   = 2'd1,
        PS_BUS     = 2'd2,
        PS_SEQ_ALT = 2'd3
    } pc_src_e;

    typedef enum logic {
        MS_ADDER  = 1'b0,
        MS_VECTOR = 1'b1
    } mar_src_e;

endpackage

// File: rtl/abu_sext.sv
// Module abu_sext: widens a two's-complement field by copying its top bit.
// Assumes OUT_W >= IN_W.
module abu_sext #(
    parameter int IN_W  = 9,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  fld,
    output logic [OUT_W-1:0] wide
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            // replicate sign bit into the upper bits
            assign wide = {{PAD_W{fld[IN_W-1]}}, fld};
        end else begin : g_same
            // no widening needed
            assign wide = fld;
        end
    endgenerate
endmodule

// File: rtl/abu_adder.sv
// Module abu_adder: the shared address adder. It picks the base operand
// (incremented PC, base register, jump register or zero) and the offset
// (sign-extended long field, sign-extended short field or zero), then sums
// them modulo 2^DATA_W. Assumes SHORT_W < LONG_W, so both offsets sit in
// the low LONG_W bits of the field.
module abu_adder
    import abu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LONG_W  = 9,
    parameter int SHORT_W = 6
) (
    input  addr_mode_e        mode,
    input  logic [LONG_W-1:0] offs_fld,
    input  logic [DATA_W-1:0] pc_inc,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] jump_val,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] long_ext;
    logic [DATA_W-1:0] short_ext;
    logic [DATA_W-1:0] op_base;
    logic [DATA_W-1:0] op_offs;

    abu_sext #(.IN_W(LONG_W), .OUT_W(DATA_W)) u_sext_long (
        .fld  (offs_fld),
        .wide (long_ext)
    );

    abu_sext #(.IN_W(SHORT_W), .OUT_W(DATA_W)) u_sext_short (
        .fld  (offs_fld[SHORT_W-1:0]),
        .wide (short_ext)
    );

    // operand selection per addressing form
    always_comb begin
        unique case (mode)
            AM_PCREL: begin
                op_base = pc_inc;
                op_offs = long_ext;
            end
            AM_BASEOFF: begin
                op_base = base_val;
                op_offs = short_ext;
            end
            AM_REGJMP: begin
                op_base = jump_val;
                op_offs = '0;
            end
            default: begin
                op_base = '0;
                op_offs = long_ext;
            end
        endcase
    end

    // modulo-2^DATA_W sum; carry out is dropped on purpose
    assign sum = op_base + op_offs;
endmodule

// File: rtl/abu_cond.sv
// Module abu_cond: tests a branch condition mask against the flags. Each
// mask bit enables one flag; the branch condition holds when any enabled
// flag is set. Assumes the mask and flag vectors use the same bit order.
module abu_cond #(
    parameter int COND_W = 3
) (
    input  logic [COND_W-1:0] mask,
    input  logic [COND_W-1:0] flags,
    output logic              hit
);
    logic [COND_W-1:0] pair;

    genvar gi;
    generate
        for (gi = 0; gi < COND_W; gi++) begin : g_pair
            // one AND term per mask/flag pair
            assign pair[gi] = mask[gi] & flags[gi];
        end
    endgenerate

    // OR-reduce the per-flag terms
    assign hit = |pair;
endmodule

// File: rtl/addr_branch_unit.sv
// Module addr_branch_unit: forms the memory address, next PC, branch-taken
// flag and load-effective-address value for one instruction step, with all
// outputs registered. Assumes instr_fld holds instruction bits 11..0, with
// the condition mask directly above the long offset field, and that the
// sequencer holds the select inputs stable for the cycle being computed.
module addr_branch_unit
    import abu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LONG_W  = 9,
    parameter int SHORT_W = 6,
    parameter int VEC_W   = 8,
    parameter int COND_W  = 3,
    localparam int FLD_W  = LONG_W + COND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLD_W-1:0]  instr_fld,
    input  logic [DATA_W-1:0] pc_inc,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] jump_val,
    input  logic [DATA_W-1:0] bus_val,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_p,
    input  logic [1:0]        addr_mode,
    input  logic [1:0]        pc_sel,
    input  logic              mar_sel,
    input  logic              cond_br,
    output logic [DATA_W-1:0] mar_addr,
    output logic [DATA_W-1:0] next_pc,
    output logic              br_taken,
    output logic [DATA_W-1:0] lea_val
);
    localparam int COND_LSB = LONG_W;
    localparam int COND_MSB = LONG_W + COND_W - 1;
    localparam int VEC_PAD  = DATA_W - VEC_W;

    addr_mode_e        mode_q;
    pc_src_e           pc_src;
    mar_src_e          mar_src;
    logic [DATA_W-1:0] adder_sum;
    logic [COND_W-1:0] flag_vec;
    logic              cond_hit;
    logic              redirect;
    logic [DATA_W-1:0] vec_addr;
    logic [DATA_W-1:0] mar_d;
    logic [DATA_W-1:0] pc_d;

    assign mode_q   = addr_mode_e'(addr_mode);
    assign pc_src   = pc_src_e'(pc_sel);
    assign mar_src  = mar_src_e'(mar_sel);
    assign flag_vec = {flag_n, flag_z, flag_p};
    assign vec_addr = {{VEC_PAD{1'b0}}, instr_fld[VEC_W-1:0]};

    abu_adder #(.DATA_W(DATA_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_adder (
        .mode     (mode_q),
        .offs_fld (instr_fld[LONG_W-1:0]),
        .pc_inc   (pc_inc),
        .base_val (base_val),
        .jump_val (jump_val),
        .sum      (adder_sum)
    );

    abu_cond #(.COND_W(COND_W)) u_cond (
        .mask  (instr_fld[COND_MSB:COND_LSB]),
        .flags (flag_vec),
        .hit   (cond_hit)
    );

    // adder redirect: unconditional, or gated by the condition mask
    assign redirect = (pc_src == PS_ADDER) && (!cond_br || cond_hit);

    // PC source selection
    always_comb begin
        unique case (pc_src)
            PS_ADDER: pc_d = redirect ? adder_sum : pc_inc;
            PS_BUS:   pc_d = bus_val;
            default:  pc_d = pc_inc;
        endcase
    end

    // memory address source selection
    assign mar_d = (mar_src == MS_VECTOR) ? vec_addr : adder_sum;

    // output registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_addr <= '0;
            next_pc  <= '0;
            br_taken <= 1'b0;
            lea_val  <= '0;
        end else begin
            mar_addr <= mar_d;
            next_pc  <= pc_d;
            br_taken <= redirect;
            lea_val  <= adder_sum;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(!rst_n) |-> (mar_addr == '0 && next_pc == '0 && !br_taken && lea_val == '0)); // R1

    AST_MASK_NONE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pc_sel == 2'd1 && cond_br && instr_fld[COND_MSB:COND_LSB] == '0))
        |-> (!br_taken && next_pc == $past(pc_inc))); // R10

    AST_MASK_ALL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pc_sel == 2'd1 && cond_br && (&instr_fld[COND_MSB:COND_LSB])
                               && (flag_n | flag_z | flag_p)))
        |-> (br_taken && next_pc == lea_val)); // R10

    AST_VECTOR_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mar_sel))
        |-> (mar_addr[DATA_W-1:VEC_W] == '0 && mar_addr[VEC_W-1:0] == $past(instr_fld[VEC_W-1:0]))); // R7

    AST_MAR_FOLLOWS_LEA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!mar_sel)) |-> (mar_addr == lea_val)); // R6

    AST_BUS_TO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pc_sel == 2'd2)) |-> (next_pc == $past(bus_val) && !br_taken)); // R8

    AST_JUMP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr_mode == 2'd2)) |-> (lea_val == $past(jump_val))); // R4

    AST_TAKEN_USES_ADDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && br_taken) |-> (next_pc == lea_val)); // R11

endmodule

// File: tb/addr_branch_unit_bench.sv
module addr_branch_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] instr_fld;
    logic [15:0] pc_inc, base_val, jump_val, bus_val;
    logic        flag_n, flag_z, flag_p;
    logic [1:0]  addr_mode, pc_sel;
    logic        mar_sel, cond_br;
    logic [15:0] mar_addr, next_pc, lea_val;
    logic        br_taken;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_branch_unit u_addr_branch_unit (
        .clk(clk), .rst_n(rst_n), .instr_fld(instr_fld), .pc_inc(pc_inc),
        .base_val(base_val), .jump_val(jump_val), .bus_val(bus_val),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .addr_mode(addr_mode), .pc_sel(pc_sel), .mar_sel(mar_sel), .cond_br(cond_br),
        .mar_addr(mar_addr), .next_pc(next_pc), .br_taken(br_taken), .lea_val(lea_val)
    );

    // expected adder result from R2..R5, R12
    function automatic logic [15:0] exp_sum();
        logic [15:0] s9, s6;
        s9 = {{7{instr_fld[8]}}, instr_fld[8:0]};
        s6 = {{10{instr_fld[5]}}, instr_fld[5:0]};
        case (addr_mode)
            2'd0:    return pc_inc + s9;
            2'd1:    return base_val + s6;
            2'd2:    return jump_val;
            default: return s9;
        endcase
    endfunction

    // expected redirect from R8..R11
    function automatic logic exp_taken();
        logic hit;
        hit = (instr_fld[11] & flag_n) | (instr_fld[10] & flag_z) | (instr_fld[9] & flag_p);
        return (pc_sel == 2'd1) && (!cond_br || hit);
    endfunction

    function automatic logic [15:0] exp_pc();
        if (pc_sel == 2'd2) return bus_val;
        if (exp_taken())    return exp_sum();
        return pc_inc;
    endfunction

    function automatic logic [15:0] exp_mar();
        return mar_sel ? {8'h00, instr_fld[7:0]} : exp_sum();
    endfunction

    task automatic cmp16(string tag, string what, logic [15:0] act, logic [15:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive at negedge, let one rising edge register, sample at next negedge
    task automatic apply(string tag, logic [1:0] md, logic [1:0] ps, logic ms, logic cb,
                         logic [11:0] fld, logic [15:0] pc, logic [15:0] bs,
                         logic [15:0] jv, logic [15:0] bv, logic [2:0] nzp);
        logic [15:0] e_mar, e_pc, e_lea;
        logic        e_tk;
        addr_mode = md; pc_sel = ps; mar_sel = ms; cond_br = cb;
        instr_fld = fld; pc_inc = pc; base_val = bs; jump_val = jv; bus_val = bv;
        {flag_n, flag_z, flag_p} = nzp;
        e_mar = exp_mar(); e_pc = exp_pc(); e_lea = exp_sum(); e_tk = exp_taken();
        @(posedge clk);
        @(negedge clk);
        vectors++;
        cmp16(tag, "lea_val", lea_val, e_lea);
        cmp16(tag, "mar_addr", mar_addr, e_mar);
        cmp16(tag, "next_pc", next_pc, e_pc);
        if (br_taken !== e_tk) begin
            miscompares++;
            $display("FAIL %s br_taken: actual %b expected %b", tag, br_taken, e_tk);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        addr_mode = 2'd0; pc_sel = 2'd1; mar_sel = 1'b0; cond_br = 1'b0;
        instr_fld = 12'hFFF; pc_inc = 16'h1234; base_val = 16'h5678;
        jump_val = 16'h9ABC; bus_val = 16'hDEF0; {flag_n, flag_z, flag_p} = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while reset is held with nonzero inputs
        vectors++;
        cmp16("R1", "mar_addr", mar_addr, 16'h0);
        cmp16("R1", "next_pc", next_pc, 16'h0);
        cmp16("R1", "lea_val", lea_val, 16'h0);
        if (br_taken !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 br_taken: actual %b expected 0", br_taken);
        end
        rst_n = 1'b1;

        // R2: long offset extremes
        apply("R2", 2'd0, 2'd0, 1'b0, 1'b0, 12'h0FF, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b010);
        cmp16("R2", "plus255", lea_val, 16'h30FF);
        apply("R2", 2'd0, 2'd0, 1'b0, 1'b0, 12'h100, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b010);
        cmp16("R2", "minus256", lea_val, 16'h2F00);
        // R3: short offset extremes, upper field bits must not matter
        apply("R3", 2'd1, 2'd0, 1'b0, 1'b0, 12'hFDF, 16'h0, 16'h1000, 16'h0, 16'h0, 3'b001);
        cmp16("R3", "plus31", lea_val, 16'h101F);
        apply("R3", 2'd1, 2'd0, 1'b0, 1'b0, 12'h020, 16'h0, 16'h1000, 16'h0, 16'h0, 3'b001);
        cmp16("R3", "minus32", lea_val, 16'h0FE0);
        // R4: register jump, unconditional redirect
        apply("R4", 2'd2, 2'd1, 1'b0, 1'b0, 12'h1FF, 16'h4000, 16'h0, 16'hBEEF, 16'h0, 3'b100);
        cmp16("R4", "jump", next_pc, 16'hBEEF);
        // R5: zero-based
        apply("R5", 2'd3, 2'd0, 1'b0, 1'b0, 12'h1F0, 16'h4000, 16'h0, 16'h0, 16'h0, 3'b100);
        cmp16("R5", "zero_base", lea_val, 16'hFFF0);
        // R6 and R7: vector on MAR while LEA keeps the adder value
        apply("R7", 2'd0, 2'd0, 1'b1, 1'b0, 12'hFA5, 16'h2000, 16'h0, 16'h0, 16'h0, 3'b010);
        cmp16("R7", "vector", mar_addr, 16'h00A5);
        cmp16("R6", "lea_with_vector", lea_val, 16'h1FA5);
        // R8: bus, sequential and alternate sequential
        apply("R8", 2'd0, 2'd2, 1'b0, 1'b1, 12'h000, 16'h2222, 16'h0, 16'h0, 16'h1234, 3'b001);
        cmp16("R8", "bus", next_pc, 16'h1234);
        apply("R8", 2'd0, 2'd0, 1'b0, 1'b0, 12'h010, 16'h2222, 16'h0, 16'h0, 16'h1234, 3'b001);
        cmp16("R8", "seq", next_pc, 16'h2222);
        apply("R8", 2'd0, 2'd3, 1'b0, 1'b0, 12'h010, 16'h2223, 16'h0, 16'h0, 16'h1234, 3'b001);
        cmp16("R8", "seq_alt", next_pc, 16'h2223);
        // R9: single-flag matches and mismatches
        apply("R9", 2'd0, 2'd1, 1'b0, 1'b1, 12'h405, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b010);
        cmp16("R9", "z_match", next_pc, 16'h3005);
        apply("R9", 2'd0, 2'd1, 1'b0, 1'b1, 12'h805, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b001);
        cmp16("R9", "n_vs_p_miss", next_pc, 16'h3000);
        // R10: empty mask and full mask
        apply("R10", 2'd0, 2'd1, 1'b0, 1'b1, 12'h0FA, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b111);
        cmp16("R10", "mask_none", next_pc, 16'h3000);
        apply("R10", 2'd0, 2'd1, 1'b0, 1'b1, 12'hFFA, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b100);
        cmp16("R10", "mask_all", next_pc, 16'h2FFA);
        // R11: taken flag on an unconditional PC-relative redirect
        apply("R11", 2'd0, 2'd1, 1'b0, 1'b0, 12'h000, 16'h0100, 16'h0, 16'h0, 16'h0, 3'b000);
        if (br_taken !== 1'b1) begin
            miscompares++;
            $display("FAIL R11 br_taken: actual %b expected 1", br_taken);
        end
        // R12: wrap in both directions
        apply("R12", 2'd0, 2'd0, 1'b0, 1'b0, 12'h001, 16'hFFFF, 16'h0, 16'h0, 16'h0, 3'b010);
        cmp16("R12", "wrap_up", lea_val, 16'h0000);
        apply("R12", 2'd1, 2'd0, 1'b0, 1'b0, 12'h03F, 16'h0, 16'h0000, 16'h0, 16'h0, 3'b010);
        cmp16("R12", "wrap_down", lea_val, 16'hFFFF);

        // random mix, flags and mask drawn independently
        for (int i = 0; i < N_RANDOM; i++) begin
            apply("random", 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                  12'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 3'($urandom));
        end

        // R1: reset reasserted mid-run clears outputs again
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        vectors++;
        cmp16("R1", "next_pc_rereset", next_pc, 16'h0);
        cmp16("R1", "mar_rereset", mar_addr, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule